// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block holds the interrupt acknowledge byte of a network controller's host interface and drives one level-sensitive interrupt line towards the host. Event sources inside the controller raise single-cycle pulses: command done, frame received, command unit no longer active and receiver stalled, plus four low-order sources such as management-cycle completion. Each pulse sets its bit in a sticky status byte. A bit stays set until the host clears it by writing a one to that position of the acknowledge byte.

A host-written mask byte gates the interrupt line. Each of the upper four status bits is suppressed when the matching mask bit is one. The lower four status bits ignore the mask entirely. Mask bit 0 acts as a global disable that holds the line low whatever is pending. The host reaches both bytes through a byte-wide port with a one-bit register select.

The line is owned by a two-state machine with the states LINE_QUIET and LINE_RAISED. The transition ASSERT goes from LINE_QUIET to LINE_RAISED when the gated pending set becomes nonzero while the global disable is clear. The transition RELEASE goes from LINE_RAISED to LINE_QUIET when that condition stops holding. In every other case the machine stays in its state. The machine samples the status and mask values that are about to be stored, so the line follows the same clock edge that updates either byte.

Top module: `nic_irq_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, the mask byte reads 0x00 and `irq` is low.
- R2: A status bit, once set, stays set across any number of cycles until a write to the acknowledge byte (`reg_sel`=0) carries a one in that bit position.
- R3: An event pulse sets its status bit at the next rising edge: `ev_cmd_done` sets 0x80, `ev_frame_rx` sets 0x40, `ev_cu_idle` sets 0x20, `ev_rx_stall` sets 0x10, and `ev_low[i]` sets bit i (0x01 to 0x08).
- R4: A write to the acknowledge byte clears every status bit written as one and leaves the bits written as zero unchanged.
- R5: If a pulse and an acknowledge clear hit the same bit in the same cycle, the bit ends up set.
- R6: A pending bit among status bits 7..4 drives `irq` only when the mask bit at the same position is zero.
- R7: Status bits 3..0 drive `irq` whatever mask bits 3..1 hold.
- R8: While mask bit 0 is one, `irq` stays low whatever is pending.
- R9: `irq` is high exactly when (status AND (NOT mask OR 0x0F)) is nonzero and mask bit 0 is zero. The line follows the same rising edge that updates either byte, so it falls on the edge of the acknowledge or mask write that removes the last enabled pending bit.
- R10: `reg_rdata` returns the status byte when `reg_sel`=0 and the mask byte when `reg_sel`=1, with no added latency.
- R11: A write to the mask byte (`reg_sel`=1) leaves the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_cmd_done | input | 1 | Command-done event pulse (bit 7) |
| ev_frame_rx | input | 1 | Frame-received event pulse (bit 6) |
| ev_cu_idle | input | 1 | Command-unit-inactive event pulse (bit 5) |
| ev_rx_stall | input | 1 | Receiver-not-ready event pulse (bit 4) |
| ev_low | input | 4 | Low-order event pulses (bits 3..0) |
| reg_wr | input | 1 | Host write strobe |
| reg_sel | input | 1 | Register select: 0 acknowledge/status, 1 mask |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Selected register contents |
| irq | output | 1 | Level interrupt to host, active high |

## Verification
Every event pulse, acknowledge write and mask write becomes visible one rising edge after it is driven. That holds for the status byte, for the mask byte and for `irq`, because the state machine decodes the next-state values of both bytes. `reg_rdata` is combinational on the select. The bench drives all stimulus on the falling edge and lets a single rising edge pass. Before the next falling edge it clears the strobes, steps `reg_sel` through both registers and compares each read and `irq` against a model that was updated once for that edge. Collision, masking and global-disable cases are driven directly, and a seeded random run mixes all three kinds of stimulus.

// File: rtl/nicirq_pkg.sv
package nicirq_pkg;

    localparam int BYTE_W       = 8;
    localparam int LOW_W        = 4;

    localparam int POS_CMD_DONE = 7;
    localparam int POS_FRAME_RX = 6;
    localparam int POS_CU_IDLE  = 5;
    localparam int POS_RX_STALL = 4;

    localparam int POS_GLOBAL_OFF = 0;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;

    typedef enum logic {
        SEL_ACK  = 1'b0,
        SEL_MASK = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/irq_sticky_status.sv
module irq_sticky_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] post_vec,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] clr_vec,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] status_next
);

    logic [DATA_W-1:0] clr_eff;

    // Clear first, then post: a same-cycle post wins over a clear.
    always_comb begin
        clr_eff     = clr_en ? clr_vec : '0;
        status_next = (status_q & ~clr_eff) | post_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_next;
        end
    end

endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate #(
    parameter int DATA_W   = 8,
    parameter int BYPASS_W = 4,
    parameter int GLOBAL_B = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr,
    input  logic [DATA_W-1:0] mask_wdata,
    input  logic [DATA_W-1:0] status_next,
    output logic [DATA_W-1:0] mask_q,
    output logic              want_irq
);

    localparam logic [DATA_W-1:0] BYPASS_MASK =
        {{(DATA_W-BYPASS_W){1'b0}}, {BYPASS_W{1'b1}}};

    logic [DATA_W-1:0] mask_next;
    logic [DATA_W-1:0] pass_vec;
    logic [DATA_W-1:0] eff_vec;

    always_comb begin
        mask_next = mask_wr ? mask_wdata : mask_q;
    end

    // Per-bit enable: low bits always pass, upper bits follow the mask.
    for (genvar b = 0; b < DATA_W; b++) begin : g_pass
        if (b < BYPASS_W) begin : g_bypass
            assign pass_vec[b] = 1'b1;
        end else begin : g_masked
            assign pass_vec[b] = ~mask_next[b];
        end
    end

    always_comb begin
        eff_vec  = status_next & pass_vec & (BYPASS_MASK | ~mask_next);
        want_irq = (|eff_vec) & ~mask_next[GLOBAL_B];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_next;
        end
    end

endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import nicirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want_irq,
    output logic irq
);

    line_state_e state_q;
    line_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET: begin
                if (want_irq) begin
                    state_d = LINE_RAISED;   // ASSERT
                end
            end
            LINE_RAISED: begin
                if (!want_irq) begin
                    state_d = LINE_QUIET;    // RELEASE
                end
            end
            default: state_d = LINE_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq = (state_q == LINE_RAISED);
    end

endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
    import nicirq_pkg::*;
#(
    parameter int DATA_W   = BYTE_W,
    parameter int BYPASS_W = LOW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_cmd_done,
    input  logic              ev_frame_rx,
    input  logic              ev_cu_idle,
    input  logic              ev_rx_stall,
    input  logic [BYPASS_W-1:0] ev_low,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    logic [DATA_W-1:0] post_vec;
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] status_next;
    logic [DATA_W-1:0] mask_q;
    logic              ack_wr;
    logic              mask_wr;
    logic              want_irq;

    always_comb begin
        post_vec               = '0;
        post_vec[BYPASS_W-1:0] = ev_low;
        post_vec[POS_CMD_DONE] = ev_cmd_done;
        post_vec[POS_FRAME_RX] = ev_frame_rx;
        post_vec[POS_CU_IDLE]  = ev_cu_idle;
        post_vec[POS_RX_STALL] = ev_rx_stall;
    end

    always_comb begin
        ack_wr  = reg_wr && (reg_sel == SEL_ACK);
        mask_wr = reg_wr && (reg_sel == SEL_MASK);
    end

    irq_sticky_status #(
        .DATA_W (DATA_W)
    ) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .post_vec    (post_vec),
        .clr_en      (ack_wr),
        .clr_vec     (reg_wdata),
        .status_q    (status_q),
        .status_next (status_next)
    );

    irq_mask_gate #(
        .DATA_W   (DATA_W),
        .BYPASS_W (BYPASS_W),
        .GLOBAL_B (POS_GLOBAL_OFF)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask_wr     (mask_wr),
        .mask_wdata  (reg_wdata),
        .status_next (status_next),
        .mask_q      (mask_q),
        .want_irq    (want_irq)
    );

    irq_line_fsm u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .want_irq (want_irq),
        .irq      (irq)
    );

    always_comb begin
        reg_rdata = (reg_sel == SEL_MASK) ? mask_q : status_q;
    end

endmodule

// File: rtl/nic_irq_ctrl_chk.sv
module nic_irq_ctrl_chk #(
    parameter int DATA_W   = 8,
    parameter int BYPASS_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic [DATA_W-1:0] status_q,
    input logic [DATA_W-1:0] mask_q,
    input logic              ev_cmd_done,
    input logic              ev_frame_rx,
    input logic              ev_cu_idle,
    input logic              ev_rx_stall,
    input logic [BYPASS_W-1:0] ev_low,
    input logic              reg_wr,
    input logic              reg_sel,
    input logic [DATA_W-1:0] reg_wdata
);

    localparam logic [DATA_W-1:0] LOW_SET =
        {{(DATA_W-BYPASS_W){1'b0}}, {BYPASS_W{1'b1}}};

    logic no_posts;
    assign no_posts = !ev_cmd_done && !ev_frame_rx && !ev_cu_idle &&
                      !ev_rx_stall && (ev_low == '0);

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && !reg_sel) |=> ((status_q & $past(status_q)) == $past(status_q))); // R2

    AST_CMD_DONE_POST: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cmd_done |=> status_q[7]); // R3

    AST_RX_STALL_POST: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_stall |=> status_q[4]); // R3

    AST_POST_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_frame_rx && reg_wr && !reg_sel && reg_wdata[6]) |=> status_q[6]); // R5

    AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q[0] |-> !irq); // R8

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((status_q & (~mask_q | LOW_SET)) != '0)); // R9

    AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (((status_q & (~mask_q | LOW_SET)) != '0) && !mask_q[0]) |-> irq); // R9

    AST_MASK_WR_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && no_posts) |=> (status_q == $past(status_q))); // R11

endmodule

bind nic_irq_ctrl nic_irq_ctrl_chk #(
    .DATA_W   (DATA_W),
    .BYPASS_W (BYPASS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq         (irq),
    .status_q    (status_q),
    .mask_q      (mask_q),
    .ev_cmd_done (ev_cmd_done),
    .ev_frame_rx (ev_frame_rx),
    .ev_cu_idle  (ev_cu_idle),
    .ev_rx_stall (ev_rx_stall),
    .ev_low      (ev_low),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata)
);

// File: tb/sim_nic_irq_ctrl.sv
`timescale 1ns/100ps
module sim_nic_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_cmd_done = 1'b0;
    logic       ev_frame_rx = 1'b0;
    logic       ev_cu_idle  = 1'b0;
    logic       ev_rx_stall = 1'b0;
    logic [3:0] ev_low = 4'h0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_status = 8'h00;
    logic [7:0] m_mask   = 8'h00;

    always #2 clk = ~clk;   // 250 MHz

    nic_irq_ctrl u0 (
        .clk (clk), .rst_n (rst_n),
        .ev_cmd_done (ev_cmd_done), .ev_frame_rx (ev_frame_rx),
        .ev_cu_idle (ev_cu_idle), .ev_rx_stall (ev_rx_stall),
        .ev_low (ev_low), .reg_wr (reg_wr), .reg_sel (reg_sel),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .irq (irq)
    );

    function automatic logic [7:0] f_status(logic [7:0] st, logic clr_en,
                                            logic [7:0] clr, logic [7:0] post);
        logic [7:0] c;
        c = clr_en ? clr : 8'h00;
        return (st & ~c) | post;
    endfunction

    function automatic logic f_irq(logic [7:0] st, logic [7:0] mk);
        return (((st & (~mk | 8'h0F)) != 8'h00) && !mk[0]);
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Reads both bytes and the line; called in the low phase after an edge.
    task automatic observe(string req);
        reg_sel = 1'b0;
        #0.5;
        check({req, " status"}, reg_rdata, m_status);
        reg_sel = 1'b1;
        #0.5;
        check({req, " mask"}, reg_rdata, m_mask);
        check({req, " irq"}, {7'd0, irq}, {7'd0, f_irq(m_status, m_mask)});
        reg_sel = 1'b0;
    endtask

    // post: {cmd_done, frame_rx, cu_idle, rx_stall, low[3:0]}
    task automatic step(logic [7:0] post, logic wr, logic sel, logic [7:0] wd,
                        string req);
        @(negedge clk);
        ev_cmd_done = post[7];
        ev_frame_rx = post[6];
        ev_cu_idle  = post[5];
        ev_rx_stall = post[4];
        ev_low      = post[3:0];
        reg_wr      = wr;
        reg_sel     = sel;
        reg_wdata   = wd;
        @(posedge clk);
        m_status = f_status(m_status, wr && !sel, wd, post);
        if (wr && sel) m_mask = wd;
        @(negedge clk);
        {ev_cmd_done, ev_frame_rx, ev_cu_idle, ev_rx_stall} = 4'h0;
        ev_low = 4'h0;
        reg_wr = 1'b0;
        observe(req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_used;
        seed_used = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        observe("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        observe("R1 after release");

        // R3: each source to its own bit
        step(8'h80, 1'b0, 1'b0, 8'h00, "R3 cmd_done 0x80");
        step(8'h00, 1'b1, 1'b0, 8'hFF, "R4 clear all");
        step(8'h40, 1'b0, 1'b0, 8'h00, "R3 frame_rx 0x40");
        step(8'h20, 1'b0, 1'b0, 8'h00, "R3 cu_idle 0x20");
        step(8'h10, 1'b0, 1'b0, 8'h00, "R3 rx_stall 0x10");
        step(8'h05, 1'b0, 1'b0, 8'h00, "R3 low bits 0x05");
        // R2: hold over idle cycles
        for (int i = 0; i < 4; i++) step(8'h00, 1'b0, 1'b0, 8'h00, "R2 sticky hold");
        // R4: partial clear
        step(8'h00, 1'b1, 1'b0, 8'h41, "R4 partial clear");
        // R5: collision
        step(8'h40, 1'b1, 1'b0, 8'h40, "R5 post wins");
        step(8'h00, 1'b1, 1'b0, 8'hFF, "R9 release on ack");
        check("R9 line low after final ack", {7'd0, irq}, 8'h00);

        // R6: upper masked
        step(8'h00, 1'b1, 1'b1, 8'hF0, "R6 mask upper");
        step(8'h40, 1'b0, 1'b0, 8'h00, "R6 masked frame_rx");
        check("R6 irq held low", {7'd0, irq}, 8'h00);
        step(8'h00, 1'b1, 1'b1, 8'hB0, "R6 unmask bit6 raises");
        check("R6 irq high", {7'd0, irq}, 8'h01);
        step(8'h00, 1'b1, 1'b1, 8'hF0, "R9 release on mask write");
        // R7: low nibble bypass
        step(8'h00, 1'b1, 1'b1, 8'hFE, "R7 mask bits 3..1");
        step(8'h02, 1'b0, 1'b0, 8'h00, "R7 bypass low bit");
        check("R7 irq high", {7'd0, irq}, 8'h01);
        // R8: global disable
        step(8'h00, 1'b1, 1'b1, 8'h01, "R8 global off");
        check("R8 irq low", {7'd0, irq}, 8'h00);
        // R11: mask write keeps status
        step(8'h00, 1'b1, 1'b1, 8'h00, "R11 mask write keeps status");
        step(8'h00, 1'b1, 1'b0, 8'hFF, "R4 clear all again");
        // R10 checked in every observe; random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] p;
            logic [2:0] k;
            p = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
            k = 3'($urandom);
            if (k < 3)       step(p, 1'b1, 1'b0, 8'($urandom), "R4 R5 random ack");
            else if (k == 3) step(p, 1'b1, 1'b1, 8'($urandom) & 8'hFE, "R6 R7 random mask");
            else if (k == 4) step(p, 1'b1, 1'b1, 8'($urandom), "R8 R10 random mask");
            else             step(p, 1'b0, 1'b0, 8'h00, "R2 R9 random post");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule